// File: doc/BRIEF.md
# Always-On Seconds Counter with Deferred Register Writes

This block is a register-mapped real-time counter meant to sit in a domain that stays powered when the rest of the chip sleeps. It keeps a 32-bit seconds count and a fractional sub-second count, compares the pair against a programmable alarm, and raises one interrupt line from a small set of enabled status flags. The slow time base is modelled by a one-cycle tick-enable input. Each tick advances the fractional count. Each wrap of the fractional count advances the seconds count.

Software reaches the block through a plain 32-bit register port: address, write strobe, write data and combinational read data. A write does not take effect at once. It is captured by a two-state write port. In state `WP_IDLE`, an acceptable write makes the *accept* transition to `WP_HOLD`. In `WP_HOLD`, the write waits for a fixed number of ticks and then makes the *commit* transition back to `WP_IDLE`. The commit applies the captured value and sets a completion flag. While the port is in `WP_HOLD`, a second write is turned away and flagged as an error.

After reset the block reports itself as not yet valid. In that state it refuses every write except one to the status register. Even once it is valid and enabled, the seconds count stays still until software has loaded the seconds word.

Top module: `rtc_keeper`

## Requirements
- R1: After reset, seconds, fraction, alarm fraction, control and interrupt-enable read 0. Alarm seconds reads 0xFFFFFFFF. Status reads 0x202, which is the not-valid bit 1 plus the ready bit 9. The interrupt output is low.
- R2: An accepted write moves the port to the hold state, with status bit 10 (busy) at 1 and bit 9 (ready) at 0. The write takes effect at the clock edge of the WR_LAT-th tick pulse seen in the hold state. After that edge, busy is 0 and ready is 1.
- R3: The edge that commits a write sets status bit 8 (done). The one exception is a committed status write that has bit 8 set; that write clears the done flag instead.
- R4: A write that arrives while busy is discarded and sets status bit 7 (error) at the next edge. A status write with bit 7 set clears the error flag, but a new rejection in the same cycle wins.
- R5: While status bit 1 (not-valid) is set, writes to any address other than status (5) are discarded and set the error flag. Committing a status write with bits 1 and 0 both set clears bit 1 and bit 0. Setting bit 1 alone leaves the block not valid.
- R6: The counters advance only when control bit 3 is set and the seconds word has been committed at least once since reset.
- R7: The fraction is FRAC_W bits wide and increments once per tick while running. Its wrap from all-ones to 0 adds one to seconds. A committed fraction or seconds write loads that word in place of its increment.
- R8: Status bit 4 (alarm) sets one edge after seconds and fraction equal alarm seconds and alarm fraction. If alarm seconds is 0xFFFFFFFF, the alarm never sets. A status write with bit 4 clears the flag, but the compare wins in the same cycle.
- R9: The interrupt output is a register. It holds the OR of status bits 9, 8, 7 and 4, each ANDed with the same bit of the interrupt-enable register, taken one edge earlier. Interrupt-enable keeps only bits 9, 8, 7 and 4.
- R10: The word addresses are: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt-enable. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse from the slow time base |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with a 3-bit fraction and a write latency of 2 ticks. With these values, a fraction wrap comes every 8 ticks and a write commits in a handful of cycles. A short tick sweep therefore crosses several carries into the seconds word, meets the alarm compare, and packs a write collision, the not-valid lock and its release, and the unset-alarm case into a few hundred cycles. After every clock edge the bench reads back all seven registers and the interrupt, and compares each against an arithmetic model of the counters and flags.

// File: rtl/rtc_keeper_pkg.sv
package rtc_keeper_pkg;
    // Word addresses (software-visible layout)
    localparam logic [2:0] RA_SEC      = 3'd0;
    localparam logic [2:0] RA_FRAC     = 3'd1;
    localparam logic [2:0] RA_ALM_SEC  = 3'd2;
    localparam logic [2:0] RA_ALM_FRAC = 3'd3;
    localparam logic [2:0] RA_CTRL     = 3'd4;
    localparam logic [2:0] RA_STAT     = 3'd5;
    localparam logic [2:0] RA_IEN      = 3'd6;

    // Status and control bit positions
    localparam int B_BUSY = 10;
    localparam int B_NEXT = 9;
    localparam int B_DONE = 8;
    localparam int B_ERR  = 7;
    localparam int B_ALM  = 4;
    localparam int B_NV   = 1;
    localparam int B_SV   = 0;
    localparam int B_RUN  = 3;

    localparam logic [31:0] IEN_MASK  = (32'd1 << B_NEXT) | (32'd1 << B_DONE)
                                      | (32'd1 << B_ERR)  | (32'd1 << B_ALM);
    localparam logic [31:0] W1C_MASK  = (32'd1 << B_DONE) | (32'd1 << B_ERR)
                                      | (32'd1 << B_ALM)  | (32'd1 << B_NV)
                                      | (32'd1 << B_SV);
    localparam logic [31:0] CTRL_MASK = 32'd1 << B_RUN;

    typedef enum logic {
        WP_IDLE,
        WP_HOLD
    } wp_state_e;
endpackage

// File: rtl/rtc_keeper_wrport.sv
module rtc_keeper_wrport
    import rtc_keeper_pkg::*;
#(
    parameter int WR_LAT = 4,
    parameter int AW     = 3,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          locked,
    output logic          busy,
    output logic          reject,
    output logic          commit,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data
);
    localparam int            CW   = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_LAT - 1);

    wp_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          accept;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WP_IDLE: if (accept) state_d = WP_HOLD;
            WP_HOLD: if (commit) state_d = WP_IDLE;
            default: state_d = WP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WP_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        busy   = (state_q == WP_HOLD);
        reject = req_we && (busy || (locked && req_addr != RA_STAT));
        accept = req_we && !reject;
        commit = busy && tick_en && (cnt_q == LAST);
    end

    // Capture and tick counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmt_addr <= '0;
            cmt_data <= '0;
        end else if (accept) begin
            cnt_q    <= '0;
            cmt_addr <= req_addr;
            cmt_data <= req_wdata;
        end else if (busy && tick_en && !commit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_we));
    // R2
    commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> busy);
endmodule

// File: rtl/rtc_keeper_timebase.sv
module rtc_keeper_timebase
    import rtc_keeper_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run_en,
    input  logic              commit,
    input  logic [2:0]        cmt_addr,
    input  logic [SEC_W-1:0]  cmt_data,
    output logic [SEC_W-1:0]  sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic [SEC_W-1:0]  asec_q,
    output logic [FRAC_W-1:0] afrac_q,
    output logic              alarm_hit
);
    localparam logic [FRAC_W-1:0] FMAX = '1;

    logic armed_q;
    logic running, adv, roll;
    logic ld_sec, ld_frac, ld_asec, ld_afrac;

    always_comb begin
        running   = run_en && armed_q;
        adv       = running && tick_en;
        roll      = adv && (frac_q == FMAX);
        ld_sec    = commit && (cmt_addr == RA_SEC);
        ld_frac   = commit && (cmt_addr == RA_FRAC);
        ld_asec   = commit && (cmt_addr == RA_ALM_SEC);
        ld_afrac  = commit && (cmt_addr == RA_ALM_FRAC);
        alarm_hit = (asec_q != '1) && (sec_q == asec_q) && (frac_q == afrac_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sec_q   <= '0;
            frac_q  <= '0;
            asec_q  <= '1;
            afrac_q <= '0;
        end else begin
            if (adv)     frac_q  <= frac_q + 1'b1;
            if (roll)    sec_q   <= sec_q + 1'b1;
            if (ld_frac) frac_q  <= cmt_data[FRAC_W-1:0];
            if (ld_sec) begin
                sec_q   <= cmt_data;
                armed_q <= 1'b1;
            end
            if (ld_asec)  asec_q  <= cmt_data;
            if (ld_afrac) afrac_q <= cmt_data[FRAC_W-1:0];
        end
    end

    // R6
    unarmed_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !ld_sec) |=> $stable(sec_q));
    // R7
    carry_into_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && frac_q == FMAX && !ld_sec) |=> (sec_q == $past(sec_q) + 1'b1));
    // R7
    frac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ld_frac) |=> $stable(frac_q));
endmodule

// File: rtl/rtc_keeper_status.sv
module rtc_keeper_status
    import rtc_keeper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic [2:0]  cmt_addr,
    input  logic [31:0] cmt_data,
    input  logic        wr_reject,
    input  logic        busy,
    input  logic        alarm_hit,
    output logic        locked,
    output logic        run_en,
    output logic [31:0] stat_word,
    output logic [31:0] ien_word,
    output logic        irq
);
    logic        done_q, err_q, alm_q, nv_q, sv_q, run_q, irq_q;
    logic [31:0] ien_q;
    logic        stat_wr;
    logic [31:0] w1c;

    always_comb begin
        stat_wr   = commit && (cmt_addr == RA_STAT);
        w1c       = stat_wr ? (cmt_data & W1C_MASK) : '0;
        stat_word = '0;
        stat_word[B_BUSY] = busy;
        stat_word[B_NEXT] = !busy;
        stat_word[B_DONE] = done_q;
        stat_word[B_ERR]  = err_q;
        stat_word[B_ALM]  = alm_q;
        stat_word[B_NV]   = nv_q;
        stat_word[B_SV]   = sv_q;
        locked   = nv_q;
        run_en   = run_q;
        ien_word = ien_q;
        irq      = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            alm_q  <= 1'b0;
            nv_q   <= 1'b1;
            sv_q   <= 1'b0;
            run_q  <= 1'b0;
            ien_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            done_q <= (done_q | commit) & ~w1c[B_DONE];
            err_q  <= (err_q & ~w1c[B_ERR]) | wr_reject;
            alm_q  <= (alm_q & ~w1c[B_ALM]) | alarm_hit;
            nv_q   <= nv_q & ~(w1c[B_NV] & w1c[B_SV]);
            sv_q   <= sv_q & ~w1c[B_SV];
            if (commit && cmt_addr == RA_CTRL) run_q <= |(cmt_data & CTRL_MASK);
            if (commit && cmt_addr == RA_IEN)  ien_q <= cmt_data & IEN_MASK;
            irq_q  <= |(stat_word & ien_q);
        end
    end

    // R3
    done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(stat_wr && cmt_data[B_DONE])) |=> done_q);
    // R4
    reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> err_q);
    // R5
    locked_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q |-> !(commit && cmt_addr != RA_STAT));
    // R8
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_q) |-> $past(alarm_hit));
endmodule

// File: rtl/rtc_keeper.sv
module rtc_keeper
    import rtc_keeper_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int WR_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic              busy, reject, commit, locked, run_en, alarm_hit;
    logic [2:0]        cmt_addr;
    logic [31:0]       cmt_data, stat_word, ien_word, sec, asec;
    logic [FRAC_W-1:0] frac, afrac;

    rtc_keeper_wrport #(.WR_LAT(WR_LAT), .AW(3), .DW(32)) u_wrport (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_we(reg_we), .req_addr(reg_addr), .req_wdata(reg_wdata),
        .locked(locked), .busy(busy), .reject(reject), .commit(commit),
        .cmt_addr(cmt_addr), .cmt_data(cmt_data)
    );

    rtc_keeper_timebase #(.FRAC_W(FRAC_W), .SEC_W(32)) u_timebase (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .commit(commit), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .sec_q(sec), .frac_q(frac), .asec_q(asec), .afrac_q(afrac),
        .alarm_hit(alarm_hit)
    );

    rtc_keeper_status u_status (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmt_addr(cmt_addr),
        .cmt_data(cmt_data), .wr_reject(reject), .busy(busy),
        .alarm_hit(alarm_hit), .locked(locked), .run_en(run_en),
        .stat_word(stat_word), .ien_word(ien_word), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            RA_SEC:      reg_rdata = sec;
            RA_FRAC:     reg_rdata = 32'(frac);
            RA_ALM_SEC:  reg_rdata = asec;
            RA_ALM_FRAC: reg_rdata = 32'(afrac);
            RA_CTRL:     reg_rdata = run_en ? CTRL_MASK : 32'd0;
            RA_STAT:     reg_rdata = stat_word;
            RA_IEN:      reg_rdata = ien_word;
            default:     reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: tb/rtc_keeper_tb_top.sv
`timescale 1ns/1ps
module rtc_keeper_tb_top;
    localparam int FW  = 3;
    localparam int LAT = 2;
    localparam logic [31:0] FMASK = (32'd1 << FW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Model state
    logic [31:0] m_sec, m_frac, m_asec, m_afrac, m_ier, m_pd;
    logic [2:0]  m_pa;
    logic        m_ctrl, m_armed, m_busy, m_wcf, m_wef, m_caf, m_nvf, m_svf, m_irq;
    int          m_cnt;

    always #2.5 clk = ~clk;

    rtc_keeper #(.FRAC_W(FW), .WR_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] stat_exp();
        return (32'(m_busy) << 10) | (32'(!m_busy) << 9) | (32'(m_wcf) << 8)
             | (32'(m_wef) << 7) | (32'(m_caf) << 4) | (32'(m_nvf) << 1) | 32'(m_svf);
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return m_sec;
            1: return m_frac;
            2: return m_asec;
            3: return m_afrac;
            4: return m_ctrl ? 32'h8 : 32'h0;
            5: return stat_exp();
            6: return m_ier;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_all();
        #1;
        for (int a = 0; a < 7; a++) begin
            reg_addr = 3'(a);
            #0.1;
            chk($sformatf("%s reg%0d", cur_req, a), reg_rdata, exp_read(a));
        end
        chk({cur_req, " irq R9"}, 32'(irq), 32'(m_irq));
    endtask

    task automatic model_edge(input bit t, input bit we, input logic [2:0] a, input logic [31:0] d);
        logic        hit, run, rej, acc, cmt, stw;
        logic [31:0] ns, nf;
        hit = (m_asec != 32'hFFFF_FFFF) && (m_sec == m_asec) && (m_frac == m_afrac);
        run = m_ctrl && m_armed;
        rej = we && (m_busy || (m_nvf && a != 3'd5));
        acc = we && !rej;
        cmt = m_busy && t && (m_cnt == LAT - 1);
        stw = cmt && (m_pa == 3'd5);
        m_irq = |({!m_busy, m_wcf, m_wef, m_caf} & {m_ier[9], m_ier[8], m_ier[7], m_ier[4]});
        ns = m_sec; nf = m_frac;
        if (run && t) begin
            nf = (m_frac + 1) & FMASK;
            if (m_frac == FMASK) ns = m_sec + 1;
        end
        if (cmt) begin
            case (m_pa)
                3'd0: begin ns = m_pd; m_armed = 1'b1; end
                3'd1: nf = m_pd & FMASK;
                3'd2: m_asec = m_pd;
                3'd3: m_afrac = m_pd & FMASK;
                3'd4: m_ctrl = m_pd[3];
                3'd6: m_ier = m_pd & 32'h390;
                default: ;
            endcase
        end
        if (cmt) m_wcf = 1'b1;
        if (stw && m_pd[8]) m_wcf = 1'b0;
        if (stw && m_pd[7]) m_wef = 1'b0;
        if (rej) m_wef = 1'b1;
        if (stw && m_pd[4]) m_caf = 1'b0;
        if (hit) m_caf = 1'b1;
        if (stw && m_pd[1] && m_pd[0]) m_nvf = 1'b0;
        if (stw && m_pd[0]) m_svf = 1'b0;
        m_sec = ns; m_frac = nf;
        if (acc) begin m_busy = 1'b1; m_cnt = 0; m_pa = a; m_pd = d; end
        else if (m_busy && t) begin
            if (cmt) m_busy = 1'b0;
            else m_cnt++;
        end
    endtask

    task automatic step(input bit t, input bit we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = t; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_edge(t, we, a, d);
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d);
        for (int i = 0; i < LAT; i++) step(1'b1, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_sec = 0; m_frac = 0; m_asec = 32'hFFFF_FFFF; m_afrac = 0; m_ier = 0;
        m_pd = 0; m_pa = 0; m_ctrl = 0; m_armed = 0; m_busy = 0; m_wcf = 0;
        m_wef = 0; m_caf = 0; m_nvf = 1; m_svf = 0; m_irq = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values, R10 address layout
        cur_req = "R1";
        check_all();
        reg_addr = 3'd5; #0.1; chk("R1 status", reg_rdata, 32'h202);
        reg_addr = 3'd2; #0.1; chk("R1 alarm sec", reg_rdata, 32'hFFFF_FFFF);
        reg_addr = 3'd7; #0.1; chk("R10 unused addr", reg_rdata, 32'h0);

        // R5 locked writes rejected; bit 1 alone does not unlock
        cur_req = "R5";
        wr(3'd0, 32'd100);
        idle(2);
        wr(3'd5, 32'h2);
        reg_addr = 3'd5; #0.1; chk("R5 still locked", reg_rdata & 32'h2, 32'h2);
        // R2 busy/ready during hold
        cur_req = "R2";
        step(1'b0, 1'b1, 3'd5, 32'h83);
        reg_addr = 3'd5; #0.1; chk("R2 busy set", reg_rdata & 32'h600, 32'h400);
        tk(LAT);
        cur_req = "R5";
        reg_addr = 3'd5; #0.1; chk("R5 unlocked", reg_rdata, 32'h300);

        // R6 enabled but never armed
        cur_req = "R6";
        wr(3'd4, 32'h8);
        tk(10);
        reg_addr = 3'd0; #0.1; chk("R6 unarmed sec", reg_rdata, 32'd0);

        // R9 interrupt gating
        cur_req = "R9";
        wr(3'd6, 32'hFFFF_FFFF);
        idle(2);
        wr(3'd6, 32'h190);
        idle(1);
        // R3 clearing done
        cur_req = "R3";
        wr(3'd5, 32'h100);
        idle(2);
        chk("R3 irq low after clear", 32'(irq), 32'd0);

        // R7 fraction load, seconds load and tick sweep
        cur_req = "R7";
        wr(3'd1, 32'd5);
        wr(3'd0, 32'd100);
        tk(20);

        // R4 collision
        cur_req = "R4";
        step(1'b0, 1'b1, 3'd2, m_sec + 1);
        step(1'b0, 1'b1, 3'd6, 32'h0);
        tk(LAT);
        idle(1);
        reg_addr = 3'd6; #0.1; chk("R4 ier untouched", reg_rdata, 32'h190);

        // R8 alarm
        cur_req = "R8";
        wr(3'd3, 32'd0);
        tk(12);
        wr(3'd5, 32'h90);
        idle(2);
        wr(3'd4, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'd2);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd5, 32'h10);
        idle(3);
        reg_addr = 3'd5; #0.1; chk("R8 unset alarm", reg_rdata & 32'h10, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule